// File: doc/BRIEF.md
# Isochronous IN Transmit Packet Tracker

This block manages the transmit buffer of an isochronous IN endpoint in a full-speed USB device controller, where data flows from the device to the host. The CPU side loads bytes one per cycle and can end a packet early with a short-packet strobe. The serial-engine side starts a packet, reads its bytes in order and reports when the packet has gone out on the bus.

Storage holds two packet slots. A slot becomes a complete packet when its 256th byte arrives or when software closes it short. The block counts complete packets and raises a service flag while the count is one or less, asking the CPU for more data. Writes that arrive while both slots hold complete packets are lost and set a sticky overflow flag. If the engine starts a packet while none is complete, the block reports an underrun and a zero-length packet.

Top module: `iso_tx_tracker`

## Requirements
- R1: After reset, `svc_o` is 1, and `ovf_o`, `tsp_o`, `tx_valid_o` and `underrun_o` are 0. No complete packet is held.
- R2: `svc_o` is 1 while at most one complete packet is held. It is 0 while two are held, and it returns to 1 once a packet is freed.
- R3: A packet closes with length 256 when its 256th byte is written. No strobe is needed.
- R4: A `tsp_i` pulse accepted with fewer than two packets held closes the current packet at the next clock edge. The packet's length is the number of bytes loaded so far.
- R5: `tsp_o` is 1 for exactly the one cycle after an accepted `tsp_i` pulse and then clears itself. A strobe with no bytes loaded creates a zero-length packet, which the engine sees as a normal packet of length 0 with no underrun.
- R6: While two complete packets are held, `wr_en_i` and `tsp_i` have no effect on the stored packets and set `ovf_o`. `ovf_o` stays at 1 until reset.
- R7: `tx_valid_o` pulses one cycle after `eng_start_i`, with `tx_len_o` giving the oldest packet's length. A `pkt_sent_i` pulse frees the oldest packet and lowers the count by one.
- R8: An `eng_start_i` pulse with no complete packet held gives `underrun_o` = 1 and `tx_len_o` = 0 on the `tx_valid_o` cycle. A following `pkt_sent_i` leaves the count unchanged.
- R9: Packets go out in the order they were closed, and their bytes go out in write order. Each `eng_rd_i` cycle advances the read position. The byte for the n-th read appears on `rd_data_o` one cycle after that read, and the position restarts at 0 on `eng_start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU byte write strobe |
| wr_data_i | input | 8 | CPU byte |
| tsp_i | input | 1 | Close current packet short |
| tsp_o | output | 1 | Short-close request pending |
| svc_o | output | 1 | Buffer wants data (one or fewer complete packets) |
| ovf_o | output | 1 | Sticky: data or strobe lost while full |
| eng_start_i | input | 1 | Engine starts the next IN packet |
| tx_valid_o | output | 1 | Packet descriptor valid (one-cycle pulse) |
| tx_len_o | output | 9 | Length of the packet being sent |
| underrun_o | output | 1 | No complete packet held at start |
| eng_rd_i | input | 1 | Engine byte read strobe |
| rd_data_o | output | 8 | Byte read, one cycle after the strobe |
| pkt_sent_i | input | 1 | Oldest packet has been transmitted |

## Verification
`svc_o`, `ovf_o` and the packet count change at the edge that samples the causing strobe. `tsp_o` is high in the cycle after the strobe edge, and the short packet closes at the edge after that. The descriptor outputs and each read byte come one edge after their strobe. The bench drives inputs on falling edges and samples each result at the falling edge that follows the edge where the result is due, so every check lands on the single cycle the timing above defines. A bench model keeps the packet lengths and bytes per slot, so overflow drops and order are checked against values computed from the requirements.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;
  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_PKT   = 2'd1,
    RSP_UNDER = 2'd2
  } tx_rsp_e;
endpackage

// File: rtl/iso_tx_fill.sv
module iso_tx_fill #(
  parameter int PKT_BYTES = 256,
  parameter int LEN_W     = $clog2(PKT_BYTES) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             tsp_i,
  input  logic             full_i,
  output logic             wr_acc_o,
  output logic [LEN_W-2:0] wr_off_o,
  output logic             commit_o,
  output logic [LEN_W-1:0] commit_len_o,
  output logic             tsp_o,
  output logic             ovf_o
);
  logic [LEN_W-1:0] fill_q, fill_after;
  logic             tsp_q, ovf_q;

  assign wr_acc_o     = wr_en_i & ~full_i;
  assign wr_off_o     = fill_q[LEN_W-2:0];
  assign fill_after   = fill_q + LEN_W'(wr_acc_o);
  assign commit_o     = ~full_i & ((fill_after == LEN_W'(PKT_BYTES)) | tsp_q);
  assign commit_len_o = fill_after;
  assign tsp_o        = tsp_q;
  assign ovf_o        = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      tsp_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      fill_q <= commit_o ? '0 : fill_after;
      // pending close waits while full; new strobe re-arms it
      tsp_q  <= (tsp_q & full_i) | (tsp_i & ~full_i);
      if (full_i && (wr_en_i || tsp_i)) ovf_q <= 1'b1;
    end
  end

  p_full_close_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc_o && fill_q == LEN_W'(PKT_BYTES - 1) |-> commit_o && commit_len_o == LEN_W'(PKT_BYTES));
  p_short_close_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsp_q && !full_i |-> commit_o);
  p_tsp_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsp_q && !full_i && !tsp_i |=> !tsp_o);
  p_ovf_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i && (wr_en_i || tsp_i) |=> ovf_o);
  p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

// File: rtl/iso_tx_queue.sv
module iso_tx_queue
  import iso_tx_pkg::*;
#(
  parameter int NUM_PKTS  = 2,
  parameter int PKT_BYTES = 256,
  parameter int LEN_W     = $clog2(PKT_BYTES) + 1,
  parameter int SLOT_W    = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [LEN_W-1:0]  commit_len_i,
  input  logic              eng_start_i,
  input  logic              eng_rd_i,
  input  logic              pkt_sent_i,
  output logic              full_o,
  output logic              svc_o,
  output logic [SLOT_W-1:0] wr_slot_o,
  output logic [SLOT_W-1:0] rd_slot_o,
  output logic [LEN_W-2:0]  rd_byte_o,
  output logic              tx_valid_o,
  output logic [LEN_W-1:0]  tx_len_o,
  output logic              underrun_o
);
  localparam int CNT_W = $clog2(NUM_PKTS + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] wr_slot_q, rd_slot_q;
  logic [LEN_W-1:0]  len_q [NUM_PKTS];
  logic [LEN_W-2:0]  rd_byte_q;
  logic [LEN_W-1:0]  tx_len_q;
  tx_rsp_e           rsp_q;
  logic              free;

  function automatic logic [SLOT_W-1:0] nxt(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(NUM_PKTS - 1)) ? '0 : p + SLOT_W'(1);
  endfunction

  assign free       = pkt_sent_i & (cnt_q != '0);
  assign full_o     = (cnt_q == CNT_W'(NUM_PKTS));
  assign svc_o      = (cnt_q < CNT_W'(NUM_PKTS));
  assign wr_slot_o  = wr_slot_q;
  assign rd_slot_o  = rd_slot_q;
  assign rd_byte_o  = rd_byte_q;
  assign tx_valid_o = (rsp_q != RSP_IDLE);
  assign underrun_o = (rsp_q == RSP_UNDER);
  assign tx_len_o   = tx_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      wr_slot_q <= '0;
      rd_slot_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(commit_i) - CNT_W'(free);
      if (commit_i) wr_slot_q <= nxt(wr_slot_q);
      if (free)     rd_slot_q <= nxt(rd_slot_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PKTS; i++) len_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_PKTS; i++)
        if (commit_i && wr_slot_q == SLOT_W'(i)) len_q[i] <= commit_len_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q     <= RSP_IDLE;
      tx_len_q  <= '0;
      rd_byte_q <= '0;
    end else begin
      rsp_q <= RSP_IDLE;
      if (eng_start_i) begin
        if (cnt_q == '0) begin
          rsp_q    <= RSP_UNDER;
          tx_len_q <= '0;
        end else begin
          rsp_q    <= RSP_PKT;
          tx_len_q <= len_q[rd_slot_q];
        end
      end
      if (eng_start_i || free) rd_byte_q <= '0;
      else if (eng_rd_i)       rd_byte_q <= rd_byte_q + 1'b1;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NUM_PKTS));
  p_svc_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !free && cnt_q == CNT_W'(NUM_PKTS - 1) |=> !svc_o);
  p_svc_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free && !commit_i |=> svc_o);
  p_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free && !commit_i |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  p_desc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_i |=> tx_valid_o);
  p_underrun_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_i && cnt_q == '0 |=> underrun_o && tx_len_o == '0);
endmodule

// File: rtl/iso_tx_mem.sv
module iso_tx_mem #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/iso_tx_tracker.sv
module iso_tx_tracker #(
  parameter int PKT_BYTES = 256,
  parameter int NUM_PKTS  = 2,
  parameter int DATA_W    = 8,
  parameter int LEN_W     = $clog2(PKT_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tsp_i,
  output logic              tsp_o,
  output logic              svc_o,
  output logic              ovf_o,
  input  logic              eng_start_i,
  output logic              tx_valid_o,
  output logic [LEN_W-1:0]  tx_len_o,
  output logic              underrun_o,
  input  logic              eng_rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              pkt_sent_i
);
  // PKT_BYTES must be a power of two: slot and offset form the address
  localparam int BYTE_W = LEN_W - 1;
  localparam int SLOT_W = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1;
  localparam int ADDR_W = SLOT_W + BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              full, wr_acc, commit;
  logic [BYTE_W-1:0] wr_off, rd_byte;
  logic [LEN_W-1:0]  commit_len;
  logic [SLOT_W-1:0] wr_slot, rd_slot;

  iso_tx_fill #(.PKT_BYTES(PKT_BYTES), .LEN_W(LEN_W)) u_fill (
    .clk_i, .rst_ni,
    .wr_en_i, .tsp_i,
    .full_i       (full),
    .wr_acc_o     (wr_acc),
    .wr_off_o     (wr_off),
    .commit_o     (commit),
    .commit_len_o (commit_len),
    .tsp_o, .ovf_o
  );

  iso_tx_queue #(.NUM_PKTS(NUM_PKTS), .PKT_BYTES(PKT_BYTES), .LEN_W(LEN_W), .SLOT_W(SLOT_W)) u_queue (
    .clk_i, .rst_ni,
    .commit_i     (commit),
    .commit_len_i (commit_len),
    .eng_start_i, .eng_rd_i, .pkt_sent_i,
    .full_o       (full),
    .svc_o,
    .wr_slot_o    (wr_slot),
    .rd_slot_o    (rd_slot),
    .rd_byte_o    (rd_byte),
    .tx_valid_o, .tx_len_o, .underrun_o
  );

  iso_tx_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i, .rst_ni,
    .we_i    (wr_acc),
    .waddr_i ({wr_slot, wr_off}),
    .wdata_i (wr_data_i),
    .re_i    (eng_rd_i),
    .raddr_i ({rd_slot, rd_byte}),
    .rdata_o (rd_data_o)
  );

  p_reset_svc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> svc_o);
endmodule

// File: tb/iso_tx_tracker_tb.sv
module iso_tx_tracker_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, tsp = 1'b0, eng_start = 1'b0, eng_rd = 1'b0, pkt_sent = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tsp_o, svc_o, ovf_o, tx_valid_o, underrun_o;
  logic [8:0] tx_len_o;
  logic [7:0] rd_data_o;

  always #2.5 clk = ~clk;

  iso_tx_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .tsp_i(tsp), .tsp_o(tsp_o),
    .svc_o(svc_o), .ovf_o(ovf_o),
    .eng_start_i(eng_start), .tx_valid_o(tx_valid_o), .tx_len_o(tx_len_o),
    .underrun_o(underrun_o), .eng_rd_i(eng_rd), .rd_data_o(rd_data_o),
    .pkt_sent_i(pkt_sent)
  );

  int n_tests = 0, n_fail = 0;
  int m_cnt = 0, m_fill = 0, m_head = 0, m_tail = 0;
  bit m_ovf = 0;
  int m_len [2];
  logic [7:0] m_dat [2][256];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_svc();
    return m_cnt <= 1;
  endfunction

  task automatic close_pkt(input int len);
    m_len[m_tail] = len;
    m_tail ^= 1;
    m_cnt++;
    m_fill = 0;
  endtask

  task automatic put_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 8'($urandom);
      if (m_cnt == 2) m_ovf = 1;
      else begin
        m_dat[m_tail][m_fill] = wr_data;
        m_fill++;
        if (m_fill == 256) close_pkt(256);
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic short_pkt();
    bit acc;
    @(negedge clk);
    tsp = 1'b1;
    acc = (m_cnt < 2);
    if (!acc) m_ovf = 1;
    @(negedge clk);
    tsp = 1'b0;
    chk(tsp_o == acc, "R5 tsp_o set after strobe", tsp_o, acc);
    @(negedge clk);
    chk(tsp_o == 1'b0, "R5 tsp_o self-clear", tsp_o, 0);
    if (acc) close_pkt(m_fill);
  endtask

  task automatic send_pkt();
    int len;
    @(negedge clk);
    eng_start = 1'b1;
    @(negedge clk);
    eng_start = 1'b0;
    chk(tx_valid_o == 1'b1, "R7 tx_valid_o pulse", tx_valid_o, 1);
    if (m_cnt == 0) begin
      chk(underrun_o == 1'b1, "R8 underrun_o", underrun_o, 1);
      chk(tx_len_o == 0, "R8 zero length on underrun", tx_len_o, 0);
      pkt_sent = 1'b1;
      @(negedge clk);
      pkt_sent = 1'b0;
      chk(svc_o == 1'b1, "R8 count unchanged", svc_o, 1);
    end else begin
      len = m_len[m_head];
      chk(underrun_o == 1'b0, "R7 no underrun with data", underrun_o, 0);
      chk(tx_len_o == len, "R7 oldest length", tx_len_o, len);
      for (int i = 0; i < len; i++) begin
        eng_rd = 1'b1;
        @(negedge clk);
        chk(rd_data_o == m_dat[m_head][i], "R9 byte order", rd_data_o, m_dat[m_head][i]);
      end
      eng_rd = 1'b0;
      pkt_sent = 1'b1;
      @(negedge clk);
      pkt_sent = 1'b0;
      m_head ^= 1;
      m_cnt--;
    end
  endtask

  task automatic check_flags(input string ctx);
    chk(svc_o == exp_svc(), {"R2 svc_o ", ctx}, svc_o, exp_svc());
    chk(ovf_o == m_ovf, {"R6 ovf_o ", ctx}, ovf_o, m_ovf);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(svc_o == 1'b1, "R1 svc_o after reset", svc_o, 1);
    chk(ovf_o == 1'b0, "R1 ovf_o after reset", ovf_o, 0);
    chk(tsp_o == 1'b0, "R1 tsp_o after reset", tsp_o, 0);
    chk(tx_valid_o == 1'b0 && underrun_o == 1'b0, "R1 engine outputs idle", tx_valid_o, 0);

    // R5 zero-length packet
    short_pkt();
    check_flags("after zlp");
    send_pkt();
    // R8 underrun on empty buffer
    send_pkt();
    // R3 full-size close, then R4 short close fills both slots
    put_bytes(256);
    chk(svc_o == 1'b1, "R3 one packet held", svc_o, 1);
    put_bytes(5);
    short_pkt();
    chk(svc_o == 1'b0, "R2 two packets held", svc_o, 0);
    // R6 drops while full
    put_bytes(3);
    short_pkt();
    check_flags("while full");
    send_pkt();
    check_flags("after one send");
    send_pkt();
    check_flags("after drain");

    for (int k = 0; k < 140; k++) begin
      r = int'($urandom % 4);
      case (r)
        0: put_bytes(int'($urandom % 200) + 1);
        1: short_pkt();
        default: send_pkt();
      endcase
      check_flags("random");
    end
    while (m_cnt > 0) send_pkt();
    check_flags("final");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule